// File: doc/BRIEF.md
# Selectable 50% Duty Clock Divider

This block takes a fast source clock and produces a slower clock from it. The ratio is 3, 4, 5 or 6 and is chosen by a two-bit select. The output is high for exactly half of every output period, and this holds for the odd ratios too. For those ratios the falling transition lands on a falling edge of the source clock. The same divided clock goes to two output pins, and the two stay in phase. Each pin has its own enable, and a disabled pin floats at high impedance. An active-high master reset clears the divider and pulls both outputs low. When reset is released, division starts again from a known point.

A small state machine runs on the rising source edge with three states. ST_START is the wait after reset. ST_HIGH and ST_LOW are the two halves of each output period. The transitions are:
- START_TO_HIGH after N rising edges have been counted in ST_START.
- HIGH_TO_LOW after floor(N/2) edges in ST_HIGH.
- LOW_TO_HIGH after the remaining N-floor(N/2) edges in ST_LOW.

Both START_TO_HIGH and LOW_TO_HIGH load the ratio for the period that is starting. For odd ratios, a second copy of the high phase is taken on the falling source edge and OR-ed in. This stretches the high time by one half cycle.

Top module: `duty_clock_divider`

## Requirements
- R1: The select picks the ratio N as follows: 2'b00 gives 3, 2'b01 gives 4, 2'b10 gives 5 and 2'b11 gives 6. The output period is N source clock periods.
- R2: For every ratio, the output high time and the output low time each equal N source half-periods.
- R3: While reset is high, every enabled output is low and the divider state is cleared. This applies at once and does not wait for a clock edge.
- R4: After reset falls, the output stays low. It first rises on the N-th rising source edge after the release.
- R5: The select value present at the rising source edge that starts a high phase sets the ratio for that whole output period. A change made later takes effect only from the next period.
- R6: Enable bit i high drives output i. Enable bit i low leaves output i at high impedance. The bits are independent, and the divider keeps running while an output is disabled.
- R7: When both outputs are enabled, they carry identical values at all times.
- R8: The output always rises on a rising source edge. It falls on a falling source edge for odd ratios and on a rising source edge for even ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Source clock to be divided |
| rst | input | 1 | Master reset, active high, asynchronous |
| div_sel | input | SEL_W | Ratio select (N = DIV_BASE + div_sel) |
| out_en | input | NUM_OUT | Per-output enable; low puts that output at high impedance |
| clk_out | output | NUM_OUT | Divided clock outputs |

## Verification
The bench measures high time and low time in source half-periods for every ratio.

**Odd ratios.** A design that drops the falling-edge phase would show high and low counts differing by one, for example 2 and 4 at ratio 3. A design that combines the two phases with the wrong gate would shift the fall onto a rising edge.

**Startup.** The startup edge is counted from reset release. An off-by-one in the start counter moves the first rise by one source cycle.

**Mid-period select change.** The select is changed just after a period begins. A design that applies the new ratio at once would produce a truncated or stretched current period.

**Enables.** Each enable is toggled separately. Crossed enables, or a divider that stops while its output is disabled, would show up as a wrong output or a lost phase.

// File: rtl/divclk_pkg.sv
package divclk_pkg;

    // Phase of the output period as seen from the rising source edge
    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_HIGH  = 2'd1,
        ST_LOW   = 2'd2
    } phase_e;

endpackage

// File: rtl/divclk_seq.sv
module divclk_seq
    import divclk_pkg::*;
#(
    parameter int SEL_W    = 2,
    parameter int DIV_BASE = 3
) (
    input  logic             clk_in,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             r_out,
    output logic             odd_out
);

    localparam int MAX_N = DIV_BASE + (1 << SEL_W) - 1;
    localparam int CNT_W = $clog2(MAX_N + 1);

    phase_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CNT_W-1:0]  n_act_q, n_act_d;
    logic [CNT_W-1:0]  sel_n, cur_n, hi_len, lo_len;
    logic              r_q, odd_q;

    assign sel_n  = CNT_W'(DIV_BASE) + CNT_W'(sel);
    assign cur_n  = (state_q == ST_START) ? sel_n : n_act_q;
    assign hi_len = cur_n >> 1;
    assign lo_len = cur_n - hi_len;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + CNT_W'(1);
        n_act_d = n_act_q;
        unique case (state_q)
            ST_START: begin
                if (cnt_q == cur_n - CNT_W'(1)) begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                    n_act_d = sel_n;
                end
            end
            ST_HIGH: begin
                if (cnt_q == hi_len - CNT_W'(1)) begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end
            end
            ST_LOW: begin
                if (cnt_q == lo_len - CNT_W'(1)) begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                    n_act_d = sel_n;
                end
            end
            default: begin
                state_d = ST_START;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_in or posedge rst) begin
        if (rst) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            n_act_q <= CNT_W'(DIV_BASE);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            n_act_q <= n_act_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk_in or posedge rst) begin
        if (rst) begin
            r_q   <= 1'b0;
            odd_q <= 1'b0;
        end else begin
            r_q   <= (state_d == ST_HIGH);
            odd_q <= n_act_d[0];
        end
    end

    assign r_out   = r_q;
    assign odd_out = odd_q;

    assert_reset_clear_R3: assert property (@(posedge clk_in)
        rst |-> (state_q == ST_START && cnt_q == '0 && !r_q));

    assert_ratio_range_R1: assert property (@(posedge clk_in) disable iff (rst)
        (state_q != ST_START) |-> (n_act_q >= CNT_W'(DIV_BASE) && n_act_q <= CNT_W'(MAX_N)));

    assert_ratio_hold_R5: assert property (@(posedge clk_in) disable iff (rst)
        (state_q == ST_HIGH) |=> $stable(n_act_q));

    assert_high_bound_R2: assert property (@(posedge clk_in) disable iff (rst)
        (state_q == ST_HIGH) |-> (cnt_q < hi_len));

    assert_low_bound_R2: assert property (@(posedge clk_in) disable iff (rst)
        (state_q == ST_LOW) |-> (cnt_q < lo_len));

    assert_quiet_start_R4: assert property (@(posedge clk_in) disable iff (rst)
        (state_q == ST_START) |-> !r_q);

endmodule

// File: rtl/divclk_merge.sv
module divclk_merge (
    input  logic clk_in,
    input  logic rst,
    input  logic r_in,
    input  logic odd_in,
    output logic q_out
);

    logic f_q;

    // Half-cycle delayed copy of the rising-edge phase
    always_ff @(negedge clk_in or posedge rst) begin
        if (rst) f_q <= 1'b0;
        else     f_q <= r_in;
    end

    assign q_out = r_in | (odd_in & f_q);

endmodule

// File: rtl/divclk_pad.sv
module divclk_pad (
    input  logic en,
    input  logic din,
    output logic pad
);

    assign pad = en ? din : 1'bz;

endmodule

// File: rtl/duty_clock_divider.sv
module duty_clock_divider #(
    parameter int SEL_W    = 2,
    parameter int DIV_BASE = 3,
    parameter int NUM_OUT  = 2
) (
    input  logic               clk_in,
    input  logic               rst,
    input  logic [SEL_W-1:0]   div_sel,
    input  logic [NUM_OUT-1:0] out_en,
    output logic [NUM_OUT-1:0] clk_out
);

    logic r_phase;
    logic odd_ratio;
    logic div_clk;

    divclk_seq #(
        .SEL_W    (SEL_W),
        .DIV_BASE (DIV_BASE)
    ) u_seq (
        .clk_in  (clk_in),
        .rst     (rst),
        .sel     (div_sel),
        .r_out   (r_phase),
        .odd_out (odd_ratio)
    );

    divclk_merge u_merge (
        .clk_in (clk_in),
        .rst    (rst),
        .r_in   (r_phase),
        .odd_in (odd_ratio),
        .q_out  (div_clk)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_pad
        divclk_pad u_pad (
            .en  (out_en[i]),
            .din (div_clk),
            .pad (clk_out[i])
        );
    end

    if (NUM_OUT > 1) begin : g_phase_chk
        assert_in_phase_R7: assert property (@(posedge clk_in) disable iff (rst)
            (out_en[1:0] == 2'b11) |-> (clk_out[0] == clk_out[1]));
    end

endmodule

// File: tb/test_duty_clock_divider.sv
module test_duty_clock_divider;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam int VEC_SEL [NV] = '{0, 1, 2, 3, 2, 0};
    localparam int VEC_N   [NV] = '{3, 4, 5, 6, 5, 3};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel = 2'b00;
    logic [1:0] oe  = 2'b11;
    logic [1:0] q;

    int checks = 0;
    int errors = 0;
    logic s0, s1, sclk;
    int   mism;

    duty_clock_divider i_duty_clock_divider (
        .clk_in  (clk),
        .rst     (rst),
        .div_sel (sel),
        .out_en  (oe),
        .clk_out (q)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Sample two time units after every source edge
    task automatic sample_half();
        @(posedge clk or negedge clk);
        #2;
        s0 = q[0];
        s1 = q[1];
        sclk = clk;
        if (s0 !== s1) mism++;
    endtask

    task automatic find_rise();
        logic prev;
        prev = 1'b1;
        for (int g = 0; g < 60; g++) begin
            sample_half();
            if (prev === 1'b0 && s0 === 1'b1) return;
            prev = s0;
        end
    endtask

    // Starts on a sample where the output has just risen; ends on the next rise
    task automatic count_period(output int hi, output int lo,
                                output logic fall_clk, output logic rise_clk);
        hi = 1; lo = 0; fall_clk = 1'bx; rise_clk = 1'bx;
        for (int g = 0; g < 60; g++) begin
            sample_half();
            if (s0 === 1'b1 && lo == 0) hi++;
            else if (s0 === 1'b0) begin
                if (lo == 0) fall_clk = sclk;
                lo++;
            end else begin
                rise_clk = sclk;
                return;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hi, lo;
        logic fc, rc;

        // Vector table walk: reset, startup, duty, edge alignment, phase
        for (int v = 0; v < NV; v++) begin
            rst = 1'b1;
            sel = 2'(VEC_SEL[v]);
            repeat (3) @(posedge clk);
            #2;
            check(q === 2'b00, "R3 outputs low in reset", int'(q), 0);
            @(negedge clk);
            #2;
            rst = 1'b0;
            for (int k = 1; k <= VEC_N[v]; k++) begin
                @(posedge clk);
                #2;
                if (k < VEC_N[v]) begin
                    if (q[0] !== 1'b0) check(1'b0, "R4 early rise", k, VEC_N[v]);
                end else begin
                    check(q[0] === 1'b1, "R4 first rise at N-th edge", int'(q[0]), 1);
                end
            end
            mism = 0;
            count_period(hi, lo, fc, rc);
            check(hi == VEC_N[v], "R2 high half-periods", hi, VEC_N[v]);
            check(lo == VEC_N[v], "R2 low half-periods", lo, VEC_N[v]);
            check(hi + lo == 2 * VEC_N[v], "R1 period for select", hi + lo, 2 * VEC_N[v]);
            check(rc === 1'b1, "R8 rise on rising source edge", int'(rc), 1);
            check(fc === ((VEC_N[v] % 2) ? 1'b0 : 1'b1), "R8 fall edge type", int'(fc),
                  (VEC_N[v] % 2) ? 0 : 1);
            check(mism == 0, "R7 outputs in phase", mism, 0);
        end

        // R5: select change just after a period starts
        rst = 1'b1;
        sel = 2'b00;
        repeat (2) @(posedge clk);
        #2;
        rst = 1'b0;
        find_rise();
        sel = 2'b11;
        count_period(hi, lo, fc, rc);
        check(hi == 3 && lo == 3, "R5 current period keeps old ratio", hi + lo, 6);
        count_period(hi, lo, fc, rc);
        check(hi == 6 && lo == 6, "R5 next period uses new ratio", hi + lo, 12);

        // R5: change during low phase also waits for the next period
        sel = 2'b01;
        for (int g = 0; g < 8; g++) sample_half();
        sel = 2'b10;
        find_rise();
        count_period(hi, lo, fc, rc);
        check(hi == 5 && lo == 5, "R5 select at period start governs", hi + lo, 10);

        // R6: independent enables
        begin
            int z1, seen0, seen1;
            oe = 2'b01; z1 = 0; seen0 = 0; seen1 = 0;
            for (int g = 0; g < 24; g++) begin
                sample_half();
                if (s1 === 1'bz) z1++;
                if (s0 === 1'b0) seen0++;
                if (s0 === 1'b1) seen1++;
            end
            check(z1 == 24, "R6 disabled output 1 floats", z1, 24);
            check(seen0 > 0 && seen1 > 0, "R6 enabled output 0 toggles", seen1, 1);
            oe = 2'b10; z1 = 0; seen0 = 0; seen1 = 0;
            for (int g = 0; g < 24; g++) begin
                sample_half();
                if (s0 === 1'bz) z1++;
                if (s1 === 1'b0) seen0++;
                if (s1 === 1'b1) seen1++;
            end
            check(z1 == 24, "R6 disabled output 0 floats", z1, 24);
            check(seen0 > 0 && seen1 > 0, "R6 enabled output 1 toggles", seen1, 1);
            oe = 2'b00;
            sample_half();
            check(q === 2'bzz, "R6 both outputs float", int'(q === 2'bzz), 1);
            oe = 2'b11;
            mism = 0;
            find_rise();
            count_period(hi, lo, fc, rc);
            check(hi == 5 && lo == 5 && mism == 0, "R6 divider kept running, R7 in phase",
                  hi + lo, 10);
        end

        // R3: reset asserted mid-run between edges
        find_rise();
        #1;
        rst = 1'b1;
        #1;
        check(q === 2'b00, "R3 reset forces low at once", int'(q), 0);
        repeat (4) @(posedge clk);
        #2;
        check(q === 2'b00, "R3 outputs stay low in reset", int'(q), 0);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule